// File: doc/BRIEF.md
# Periodic Battery Health Tester

This block decides when a backup cell is put under load for a health test, and it keeps the battery-warning flag that a system reads to learn that the cell is weak. It is clocked from the main clock. A slow time-base strobe (`tick`) advances its interval counters. The strobe is typically one pulse per millisecond, so the default parameters give a one-second load window and a daily test period. An external supervisor drives `supply_ok` high while the main supply is in tolerance. It then gives a single-cycle `recovery_done` pulse once its recovery interval has run out.

After each power-up, the recovery pulse starts a test at once. That test runs even when the warning is already set. When it passes, the warning is cleared. After every test the block counts a full period in ticks and then loads the cell again. A low reading at any clock of a load window sets the warning. A later periodic pass does not clear it; only a passing power-up test does. Losing the supply stops everything. The load is removed in the next cycle, the warning keeps its value, and the schedule waits for the next recovery pulse.

The battery comparator output is expected to arrive here already digitised and synchronised. The load switch and the open-drain output stage lie outside the block.

Top module: `batt_health_tester`

## Requirements
- R1: While reset is applied, and after it is released with `supply_ok` low, `test_load_en` and `batt_warn` are both 0.
- R2: No load window starts until `recovery_done` is seen high in a cycle after `supply_ok` has been high for at least one clock. A `recovery_done` pulse while the supply is low, during a window or during the waiting period has no effect on `test_load_en`.
- R3: A `recovery_done` pulse accepted at a clock edge raises `test_load_en` from the next cycle. It stays high until the edge at which the WINDOW_TICKS-th strobe of that window is counted; with `tick` high every cycle that is exactly WINDOW_TICKS cycles.
- R4: If `batt_low` is high at any clock edge during which `test_load_en` is high, `batt_warn` is 1 from the cycle after the window ends.
- R5: After a window ends, `test_load_en` stays low for exactly PERIOD_TICKS strobes and then rises for the next window.
- R6: A window that starts from the period schedule and sees no low reading leaves `batt_warn` unchanged, so a set warning stays set.
- R7: A window that starts from `recovery_done` and sees no low reading clears `batt_warn` when it ends.
- R8: The test after a power-up runs even when `batt_warn` is already 1.
- R9: When `supply_ok` is low at a clock edge, `test_load_en` is 0 from the next cycle, `batt_warn` keeps its value, and a new `recovery_done` is needed before any further window.
- R10: The period count after the power-up test starts from zero: the first periodic window rises PERIOD_TICKS strobes after that test ends, whatever count was reached before the supply was lost.
- R11: `batt_warn` changes only at the clock edge that ends a load window.
- R12: Window and period lengths are counted in `tick` strobes only; clocks without `tick` do not advance them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Time-base strobe that advances the interval counters |
| supply_ok | input | 1 | High while the main supply is within tolerance |
| recovery_done | input | 1 | Single-cycle pulse at the end of the recovery interval after power-up |
| batt_low | input | 1 | Digitised comparator result, high when the loaded cell is below its trip level |
| test_load_en | output | 1 | High while the test load is connected to the cell |
| batt_warn | output | 1 | Active-high battery warning |

## Verification
Both outputs come straight from registers, so every result is due in the cycle after the clock edge at which its cause is sampled. `test_load_en` follows one cycle after an accepted recovery pulse, the last strobe of an interval or a supply loss. `batt_warn` follows one cycle after the edge that closes a window. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from the same sampled inputs, and both outputs are compared with it on every falling edge, which is the point where the one-cycle delay has settled. Explicit checks also count the lengths of windows and idle gaps in cycles, both with a strobe every cycle and with a strobe every third cycle.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_TEST = 2'd2,
    ST_IDLE = 2'd3
  } bht_state_e;
endpackage

// File: rtl/bht_rst_sync.sv
module bht_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bht_interval_cnt.sv
module bht_interval_cnt #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic wrap
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap    = en && at_last && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (en) begin
      if (at_last)    cnt_d = '0;
      else            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_cnt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/bht_sched.sv
module bht_sched
  import bht_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       recovery_done,
  input  logic       win_done,
  input  logic       per_done,
  output bht_state_e state,
  output logic       pu_test
);
  bht_state_e state_q, state_d;
  logic       pu_q, pu_d;

  always_comb begin
    state_d = state_q;
    pu_d    = pu_q;
    if (!supply_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_WAIT;
        ST_WAIT: if (recovery_done) begin
                   state_d = ST_TEST;
                   pu_d    = 1'b1;
                 end
        ST_TEST: if (win_done) state_d = ST_IDLE;
        ST_IDLE: if (per_done) begin
                   state_d = ST_TEST;
                   pu_d    = 1'b0;
                 end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      pu_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pu_q    <= pu_d;
    end
  end

  assign state   = state_q;
  assign pu_test = pu_q;

  p_wait_needs_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !recovery_done) |=> state_q != ST_TEST);
  p_idle_needs_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !per_done) |=> state_q != ST_TEST);
  p_supply_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> state_q == ST_OFF);
endmodule

// File: rtl/bht_warn_flag.sv
module bht_warn_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic in_test,
  input  logic batt_low,
  input  logic test_end,
  input  logic pu_test,
  output logic warn
);
  logic seen_q, seen_d;
  logic warn_q, warn_d;
  logic low_now;

  assign low_now = seen_q || batt_low;

  always_comb begin
    seen_d = seen_q;
    if (!in_test)       seen_d = 1'b0;
    else if (batt_low)  seen_d = 1'b1;
  end

  always_comb begin
    warn_d = warn_q;
    if (test_end) begin
      if (low_now)      warn_d = 1'b1;
      else if (pu_test) warn_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      warn_q <= warn_d;
    end
  end

  assign warn = warn_q;

  p_warn_only_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !test_end |=> $stable(warn_q));
  p_low_sets_warn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_end && (seen_q || batt_low)) |=> warn_q);
  p_periodic_pass_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_end && !pu_test && warn_q) |=> warn_q);
  p_powerup_pass_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_end && pu_test && !seen_q && !batt_low) |=> !warn_q);
endmodule

// File: rtl/batt_health_tester.sv
module batt_health_tester
  import bht_pkg::*;
#(
  parameter int WINDOW_TICKS = 1000,
  parameter int PERIOD_TICKS = 86_400_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic recovery_done,
  input  logic batt_low,
  output logic test_load_en,
  output logic batt_warn
);
  logic       rst_sync_n;
  bht_state_e state;
  logic       pu_test;
  logic       in_test, in_idle;
  logic       win_wrap, per_wrap;
  logic       test_end;

  bht_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign in_test = (state == ST_TEST);
  assign in_idle = (state == ST_IDLE);

  bht_interval_cnt #(.LIMIT(WINDOW_TICKS)) u_win_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (!in_test),
    .en    (tick && in_test),
    .wrap  (win_wrap)
  );

  bht_interval_cnt #(.LIMIT(PERIOD_TICKS)) u_per_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (!in_idle),
    .en    (tick && in_idle),
    .wrap  (per_wrap)
  );

  assign test_end = win_wrap && supply_ok;

  bht_sched u_sched (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .supply_ok     (supply_ok),
    .recovery_done (recovery_done),
    .win_done      (win_wrap),
    .per_done      (per_wrap),
    .state         (state),
    .pu_test       (pu_test)
  );

  bht_warn_flag u_warn (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_test  (in_test),
    .batt_low (batt_low),
    .test_end (test_end),
    .pu_test  (pu_test),
    .warn     (batt_warn)
  );

  assign test_load_en = in_test;

  p_load_off_unsupplied_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !supply_ok |=> !test_load_en);
  p_warn_kept_on_loss_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !supply_ok |=> $stable(batt_warn));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!test_load_en && !batt_warn));
endmodule

// File: tb/batt_health_tester_tb.sv
module batt_health_tester_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 4;
  localparam int PER = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic supply_ok = 1'b0;
  logic recovery_done = 1'b0;
  logic batt_low = 1'b0;
  logic test_load_en, batt_warn;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tick_gap = 1;
  int tick_cnt = 0;
  string cur_req = "R1";

  // behavioural model: 0 off, 1 waiting, 2 loading, 3 resting
  int m_mode = 0;
  int m_left = 0;
  bit m_seen = 0;
  bit m_pu = 0;
  bit m_warn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_health_tester #(.WINDOW_TICKS(WIN), .PERIOD_TICKS(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .recovery_done(recovery_done), .batt_low(batt_low),
    .test_load_en(test_load_en), .batt_warn(batt_warn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp_v, cyc);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_warn = 0; m_seen = 0; m_pu = 0;
    end else if (!supply_ok) begin
      m_mode = 0;
    end else begin
      case (m_mode)
        0: m_mode = 1;
        1: if (recovery_done) begin m_mode = 2; m_left = WIN; m_pu = 1; m_seen = 0; end
        2: begin
          if (batt_low) m_seen = 1;
          if (tick) begin
            m_left--;
            if (m_left == 0) begin
              if (m_seen) m_warn = 1;
              else if (m_pu) m_warn = 0;
              m_mode = 3; m_left = PER;
            end
          end
        end
        default: if (tick) begin
          m_left--;
          if (m_left == 0) begin m_mode = 2; m_left = WIN; m_pu = 0; m_seen = 0; end
        end
      endcase
    end
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  always @(negedge clk) begin
    check(test_load_en == (m_mode == 2), {cur_req, " load"}, test_load_en, m_mode == 2);
    check(batt_warn == m_warn, {cur_req, " warn"}, batt_warn, m_warn);
    if (tick_gap <= 1) tick = 1'b1;
    else begin
      tick_cnt = (tick_cnt + 1) % tick_gap;
      tick = (tick_cnt == 0);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_recovery();
    recovery_done = 1'b1; @(negedge clk); recovery_done = 1'b0;
  endtask

  task automatic wait_load();
    while (!test_load_en) @(negedge clk);
  endtask

  task automatic count_high(output int n);
    n = 0;
    wait_load();
    while (test_load_en) begin n++; @(negedge clk); end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!test_load_en) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    cycles(3);
    check(!test_load_en && !batt_warn, "R1 in reset", {test_load_en, batt_warn}, 0);
    rst_n = 1'b1;
    cur_req = "R2";
    pulse_recovery();
    cycles(4);
    check(!test_load_en && !batt_warn, "R1 after release", {test_load_en, batt_warn}, 0);
    supply_ok = 1'b1;
    cycles(8);
    check(!test_load_en, "R2 no pulse no test", test_load_en, 0);

    cur_req = "R3";
    pulse_recovery();
    check(test_load_en, "R3 load next cycle", test_load_en, 1);
    n = 1;
    while (test_load_en) begin n++; @(negedge clk); end
    n--;
    check(n == WIN, "R3 window length", n, WIN);
    check(!batt_warn, "R3 pass keeps clear", batt_warn, 0);

    cur_req = "R5";
    count_low(n);
    check(n == PER, "R5 idle gap", n, PER);
    cur_req = "R4";
    cycles(1);
    batt_low = 1'b1; @(negedge clk); batt_low = 1'b0;
    check(!batt_warn, "R11 no change mid window", batt_warn, 0);
    while (test_load_en) @(negedge clk);
    check(batt_warn, "R4 low sets warning", batt_warn, 1);

    cur_req = "R6";
    cycles(3);
    pulse_recovery();
    check(!test_load_en, "R2 pulse while resting ignored", test_load_en, 0);
    count_high(n);
    check(batt_warn, "R6 periodic pass keeps warning", batt_warn, 1);

    cur_req = "R9";
    wait_load();
    pulse_recovery();
    check(test_load_en, "R2 pulse during window ignored", test_load_en, 1);
    supply_ok = 1'b0; @(negedge clk);
    check(!test_load_en, "R9 load removed", test_load_en, 0);
    check(batt_warn, "R9 warning kept", batt_warn, 1);
    cycles(5);
    supply_ok = 1'b1;
    cycles(PER + 4);
    check(!test_load_en, "R9 no test without pulse", test_load_en, 0);

    cur_req = "R8";
    pulse_recovery();
    check(test_load_en, "R8 power-up test despite warning", test_load_en, 1);
    while (test_load_en) @(negedge clk);
    check(!batt_warn, "R7 power-up pass clears", batt_warn, 0);
    cur_req = "R10";
    count_low(n);
    check(n == PER, "R10 period restarts", n, PER);

    cur_req = "R12";
    while (test_load_en) @(negedge clk);
    tick_gap = 3;
    count_low(n);
    check(n >= 3*PER - 2 && n <= 3*PER, "R12 slow idle gap", n, 3*PER);
    count_high(n);
    check(n >= 3*WIN - 2 && n <= 3*WIN, "R12 slow window", n, 3*WIN);
    cycles(5);
    summary();
  end
endmodule